// File: doc/BRIEF.md
# Send DMA Engine Life-Cycle Controller

This block supervises a send DMA engine from power-up to teardown. It holds one of seven engine states: hardware down, start-up wait, idle, running, halt wait, hardware clean-up wait and software clean-up wait. It advances on single-cycle event pulses that control and status logic present on a coded event bus. The descriptor datapath and the clean-up work are done elsewhere. Those agents are started by one-shot action strobes from this block, and they report completion back as further events.

A sticky run-request flag remembers a request to run that arrives while the engine cannot yet run, for example during start-up or recovery. Once start-up completes, the engine goes straight to running. The block decodes per-state engine controls (enable, interrupt enable, halt, drain) from its state. Two halt-error events lead to different recovery paths: one goes straight to software clean-up, the other first waits for the engine to halt. When hardware start-up begins, a parameterised window of send buffers is flagged for disarm. For debug, the block shows the state it last left and the last event it accepted.

Top module: `sdma_lifecycle_ctrl`

## Requirements
- R1: After reset the state is hardware-down (state code 0), previous-state and last-event read 0, halt is 1, enable, interrupt enable and drain are 0, the run flag is 0, and no strobe or disarm bit is set.
- R2: Events are accepted when `evt_valid` is 1 and `evt_code` is 0 go-down, 1 go-start, 2 hw-started, 3 go-running, 4 sw-cleaned, 5 hw-cleaned, 6 hw-halted, 7 go-idle, 8 error-halt A, 9 error-halt B or 10 tick. Codes 11 and above change nothing at all, including last-event. A tick changes neither the state nor the flag.
- R3: In hardware-down (0), go-start moves to start-up wait (1). Go-running moves to start-up wait and sets the run flag. Sw-cleaned pulses `teardown_done` for one cycle without a state change.
- R4: In start-up wait, hw-started moves to running (6) when the run flag is set and to idle (2) when it is clear.
- R5: In start-up wait (1), software clean-up wait (3), hardware clean-up wait (4) and halt wait (5), go-running sets the run flag and go-idle clears it, with no state change.
- R6: In idle, go-running moves to running and sets the run flag. In running, go-idle moves to halt wait (5) and clears the run flag.
- R7: In running, hw-halted and error-halt A each move to software clean-up wait (3) and pulse `start_sw_clean`. Error-halt B moves to halt wait (5) with no strobe.
- R8: In halt wait, hw-halted moves to hardware clean-up wait (4) and pulses `start_hw_clean`. In hardware clean-up wait, hw-cleaned moves to software clean-up wait and pulses `start_sw_clean`.
- R9: In software clean-up wait, sw-cleaned moves to start-up wait and pulses `start_hw_up`. In the same cycle, `disarm_mask` sets bits DISARM_LO to DISARM_HI-1 (default bits 2 to 9, value 0x03FC). At all other times the mask is 0.
- R10: Go-down always ends in hardware-down. From start-up wait or idle it pulses `teardown_done`. From running, halt wait or hardware clean-up wait it pulses `start_sw_clean`. From software clean-up wait it pulses nothing. Go-down leaves the run flag unchanged.
- R11: Enable and interrupt enable are 1 only in running. Halt is 1 in every other state. Drain is 1 only in the two clean-up wait states.
- R12: Every strobe lasts exactly one cycle, and at most one strobe is active at a time.
- R13: On each state change, `prev_state_o` takes the state that was left. On each accepted event, `last_event_o` takes its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event present this cycle |
| evt_code | input | EVT_W | Event code (see R2) |
| ctl_enable | output | 1 | Engine enable |
| ctl_irq_en | output | 1 | Engine interrupt enable |
| ctl_halt | output | 1 | Engine halt request |
| ctl_drain | output | 1 | Engine drain request |
| start_sw_clean | output | 1 | One-shot: begin software clean-up |
| start_hw_clean | output | 1 | One-shot: begin hardware clean-up |
| start_hw_up | output | 1 | One-shot: begin hardware start-up |
| teardown_done | output | 1 | One-shot: engine life cycle ended |
| disarm_mask | output | NUM_BUFS | Send buffers to disarm, valid with start_hw_up |
| run_req | output | 1 | Sticky run-request flag |
| running | output | 1 | State is running |
| state_o | output | 3 | Current state code |
| prev_state_o | output | 3 | State left at the last transition |
| last_event_o | output | 4 | Last accepted event code |

## Verification
Every result of an event is due exactly one clock after the event is presented. This covers the state, the flag, the controls, the strobes, the disarm mask and the debug values, because each passes through a single register. The bench drives an event on a falling edge, holds it for one cycle, and samples all outputs at the next falling edge. To confirm that a strobe has dropped, it waits one further idle cycle and samples again. Events that are ignored are checked by reading the state, the flag and last-event immediately after they are presented.

// File: rtl/sdma_lc_pkg.sv
package sdma_lc_pkg;

   typedef enum logic [2:0] {
      ST_DOWN     = 3'd0,
      ST_STARTUP  = 3'd1,
      ST_IDLE     = 3'd2,
      ST_SWCLEAN  = 3'd3,
      ST_HWCLEAN  = 3'd4,
      ST_HALTWAIT = 3'd5,
      ST_RUN      = 3'd6
   } lc_state_e;

   typedef enum logic [3:0] {
      EV_GO_DOWN    = 4'd0,
      EV_GO_START   = 4'd1,
      EV_HW_STARTED = 4'd2,
      EV_GO_RUN     = 4'd3,
      EV_SW_CLEANED = 4'd4,
      EV_HW_CLEANED = 4'd5,
      EV_HW_HALTED  = 4'd6,
      EV_GO_IDLE    = 4'd7,
      EV_ERR_A      = 4'd8,
      EV_ERR_B      = 4'd9,
      EV_TICK       = 4'd10
   } lc_event_e;

   localparam int unsigned EV_COUNT = 11;

   typedef struct packed {
      logic sw_clean;
      logic hw_clean;
      logic hw_start;
      logic teardown;
   } lc_action_t;

   typedef struct packed {
      logic enable;
      logic irq_en;
      logic halt;
      logic drain;
   } lc_ctl_t;

   function automatic lc_ctl_t ctl_of(lc_state_e s);
      lc_ctl_t c;
      c.enable = (s == ST_RUN);
      c.irq_en = (s == ST_RUN);
      c.halt   = (s != ST_RUN);
      c.drain  = (s == ST_SWCLEAN) || (s == ST_HWCLEAN);
      return c;
   endfunction

endpackage

// File: rtl/sdma_lc_next.sv
module sdma_lc_next
   import sdma_lc_pkg::*;
(
   input  lc_state_e  cur_state,
   input  logic       cur_flag,
   input  logic       evt_ok,
   input  lc_event_e  evt,
   output lc_state_e  nxt_state,
   output logic       nxt_flag,
   output lc_action_t nxt_act
);

   always_comb begin
      nxt_state = cur_state;
      nxt_flag  = cur_flag;
      nxt_act   = '0;
      if (evt_ok) begin
         unique case (cur_state)
            ST_DOWN: begin
               case (evt)
                  EV_GO_RUN: begin
                     nxt_flag  = 1'b1;
                     nxt_state = ST_STARTUP;
                  end
                  EV_GO_START:   nxt_state = ST_STARTUP;
                  EV_SW_CLEANED: nxt_act.teardown = 1'b1;
                  default: ;
               endcase
            end
            ST_STARTUP: begin
               case (evt)
                  EV_GO_DOWN: begin
                     nxt_state        = ST_DOWN;
                     nxt_act.teardown = 1'b1;
                  end
                  EV_HW_STARTED: nxt_state = cur_flag ? ST_RUN : ST_IDLE;
                  EV_GO_RUN:     nxt_flag  = 1'b1;
                  EV_GO_IDLE:    nxt_flag  = 1'b0;
                  default: ;
               endcase
            end
            ST_IDLE: begin
               case (evt)
                  EV_GO_DOWN: begin
                     nxt_state        = ST_DOWN;
                     nxt_act.teardown = 1'b1;
                  end
                  EV_GO_RUN: begin
                     nxt_state = ST_RUN;
                     nxt_flag  = 1'b1;
                  end
                  default: ;
               endcase
            end
            ST_SWCLEAN: begin
               case (evt)
                  EV_GO_DOWN:    nxt_state = ST_DOWN;
                  EV_GO_RUN:     nxt_flag  = 1'b1;
                  EV_GO_IDLE:    nxt_flag  = 1'b0;
                  EV_SW_CLEANED: begin
                     nxt_state        = ST_STARTUP;
                     nxt_act.hw_start = 1'b1;
                  end
                  default: ;
               endcase
            end
            ST_HWCLEAN: begin
               case (evt)
                  EV_GO_DOWN: begin
                     nxt_state        = ST_DOWN;
                     nxt_act.sw_clean = 1'b1;
                  end
                  EV_GO_RUN:  nxt_flag = 1'b1;
                  EV_GO_IDLE: nxt_flag = 1'b0;
                  EV_HW_CLEANED: begin
                     nxt_state        = ST_SWCLEAN;
                     nxt_act.sw_clean = 1'b1;
                  end
                  default: ;
               endcase
            end
            ST_HALTWAIT: begin
               case (evt)
                  EV_GO_DOWN: begin
                     nxt_state        = ST_DOWN;
                     nxt_act.sw_clean = 1'b1;
                  end
                  EV_GO_RUN:  nxt_flag = 1'b1;
                  EV_GO_IDLE: nxt_flag = 1'b0;
                  EV_HW_HALTED: begin
                     nxt_state        = ST_HWCLEAN;
                     nxt_act.hw_clean = 1'b1;
                  end
                  default: ;
               endcase
            end
            ST_RUN: begin
               case (evt)
                  EV_GO_DOWN: begin
                     nxt_state        = ST_DOWN;
                     nxt_act.sw_clean = 1'b1;
                  end
                  EV_HW_HALTED, EV_ERR_A: begin
                     nxt_state        = ST_SWCLEAN;
                     nxt_act.sw_clean = 1'b1;
                  end
                  EV_GO_IDLE: begin
                     nxt_state = ST_HALTWAIT;
                     nxt_flag  = 1'b0;
                  end
                  EV_ERR_B: nxt_state = ST_HALTWAIT;
                  default: ;
               endcase
            end
            default: nxt_state = ST_DOWN;
         endcase
      end
   end

endmodule

// File: rtl/sdma_lc_ctl_dec.sv
module sdma_lc_ctl_dec
   import sdma_lc_pkg::*;
#(
   parameter bit REGISTERED = 1'b1
)(
   input  logic      clk,
   input  logic      rst_n,
   input  lc_state_e src_state,
   output lc_ctl_t   ctl
);

   generate
      if (REGISTERED) begin : g_reg
         lc_ctl_t ctl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ctl_q <= ctl_of(ST_DOWN);
            else        ctl_q <= ctl_of(src_state);
         end
         assign ctl = ctl_q;
      end else begin : g_comb
         assign ctl = ctl_of(src_state);
      end
   endgenerate

endmodule

// File: rtl/sdma_lc_disarm.sv
module sdma_lc_disarm #(
   parameter int NUM_BUFS  = 16,
   parameter int DISARM_LO = 2,
   parameter int DISARM_HI = 10
)(
   input  logic                fire,
   output logic [NUM_BUFS-1:0] mask
);

   generate
      for (genvar i = 0; i < NUM_BUFS; i++) begin : g_bit
         if (i >= DISARM_LO && i < DISARM_HI) begin : g_in
            assign mask[i] = fire;
         end else begin : g_out
            assign mask[i] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/sdma_lifecycle_ctrl.sv
module sdma_lifecycle_ctrl
   import sdma_lc_pkg::*;
#(
   parameter int EVT_W          = 4,
   parameter int NUM_BUFS       = 16,
   parameter int DISARM_LO      = 2,
   parameter int DISARM_HI      = 10,
   parameter bit CTL_REGISTERED = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_valid,
   input  logic [EVT_W-1:0]    evt_code,
   output logic                ctl_enable,
   output logic                ctl_irq_en,
   output logic                ctl_halt,
   output logic                ctl_drain,
   output logic                start_sw_clean,
   output logic                start_hw_clean,
   output logic                start_hw_up,
   output logic                teardown_done,
   output logic [NUM_BUFS-1:0] disarm_mask,
   output logic                run_req,
   output logic                running,
   output logic [2:0]          state_o,
   output logic [2:0]          prev_state_o,
   output logic [3:0]          last_event_o
);

   generate
      if (EVT_W < 4) begin : g_bad_evt_w
         $error("EVT_W must be at least 4");
      end
      if (DISARM_LO < 0 || DISARM_LO >= DISARM_HI || DISARM_HI > NUM_BUFS) begin : g_bad_range
         $error("disarm window must be non-empty and inside NUM_BUFS");
      end
   endgenerate

   localparam logic [EVT_W-1:0] CODE_LIMIT = EVT_W'(EV_COUNT);

   logic       evt_ok;
   lc_event_e  evt;
   lc_state_e  state_q, prev_q, nxt_state;
   lc_event_e  last_q;
   logic       flag_q, nxt_flag;
   lc_action_t act_q, nxt_act;
   lc_ctl_t    ctl;

   assign evt_ok = evt_valid && (evt_code < CODE_LIMIT);
   assign evt    = lc_event_e'(evt_code[3:0]);

   sdma_lc_next u_next (
      .cur_state (state_q),
      .cur_flag  (flag_q),
      .evt_ok    (evt_ok),
      .evt       (evt),
      .nxt_state (nxt_state),
      .nxt_flag  (nxt_flag),
      .nxt_act   (nxt_act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_DOWN;
         prev_q  <= ST_DOWN;
         last_q  <= EV_GO_DOWN;
         flag_q  <= 1'b0;
         act_q   <= '0;
      end else begin
         state_q <= nxt_state;
         flag_q  <= nxt_flag;
         act_q   <= nxt_act;
         if (nxt_state != state_q) prev_q <= state_q;
         if (evt_ok)               last_q <= evt;
      end
   end

   sdma_lc_ctl_dec #(.REGISTERED(CTL_REGISTERED)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_state (CTL_REGISTERED ? nxt_state : state_q),
      .ctl       (ctl)
   );

   sdma_lc_disarm #(
      .NUM_BUFS  (NUM_BUFS),
      .DISARM_LO (DISARM_LO),
      .DISARM_HI (DISARM_HI)
   ) u_disarm (
      .fire (act_q.hw_start),
      .mask (disarm_mask)
   );

   assign ctl_enable     = ctl.enable;
   assign ctl_irq_en     = ctl.irq_en;
   assign ctl_halt       = ctl.halt;
   assign ctl_drain      = ctl.drain;
   assign start_sw_clean = act_q.sw_clean;
   assign start_hw_clean = act_q.hw_clean;
   assign start_hw_up    = act_q.hw_start;
   assign teardown_done  = act_q.teardown;
   assign run_req        = flag_q;
   assign running        = (state_q == ST_RUN);
   assign state_o        = state_q;
   assign prev_state_o   = prev_q;
   assign last_event_o   = last_q;

endmodule

// File: rtl/sdma_lc_checker.sv
module sdma_lc_checker #(
   parameter int EVT_W    = 4,
   parameter int NUM_BUFS = 16
)(
   input logic                clk,
   input logic                rst_n,
   input logic                evt_valid,
   input logic [EVT_W-1:0]    evt_code,
   input logic                ctl_enable,
   input logic                ctl_halt,
   input logic                start_sw_clean,
   input logic                start_hw_clean,
   input logic                start_hw_up,
   input logic                teardown_done,
   input logic [NUM_BUFS-1:0] disarm_mask,
   input logic                running,
   input logic [2:0]          state_o,
   input logic [3:0]          last_event_o
);

   assert_enable_matches_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_enable == running);

   assert_halt_opposes_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_halt != ctl_enable);

   assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_sw_clean, start_hw_clean, start_hw_up, teardown_done}));

   assert_sw_clean_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      start_sw_clean |=> !start_sw_clean);

   assert_hw_up_lands_startup_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_hw_up |-> (state_o == 3'd1));

   assert_disarm_with_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|disarm_mask) |-> start_hw_up);

   assert_run_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !$past(running)) |-> ($past(state_o) == 3'd1 || $past(state_o) == 3'd2));

   assert_go_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code == '0) |=> (state_o == 3'd0));

   assert_bad_code_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code >= EVT_W'(11)) |=> ($stable(state_o) && $stable(last_event_o)));

endmodule

bind sdma_lifecycle_ctrl sdma_lc_checker #(.EVT_W(EVT_W), .NUM_BUFS(NUM_BUFS)) u_lc_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .evt_valid      (evt_valid),
   .evt_code       (evt_code),
   .ctl_enable     (ctl_enable),
   .ctl_halt       (ctl_halt),
   .start_sw_clean (start_sw_clean),
   .start_hw_clean (start_hw_clean),
   .start_hw_up    (start_hw_up),
   .teardown_done  (teardown_done),
   .disarm_mask    (disarm_mask),
   .running        (running),
   .state_o        (state_o),
   .last_event_o   (last_event_o)
);

// File: tb/sdma_lifecycle_ctrl_test.sv
module sdma_lifecycle_ctrl_test;

   localparam int NB = 16;
   localparam int LO = 2;
   localparam int HI = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt_valid = 1'b0;
   logic [3:0]    evt_code = '0;
   logic          ctl_enable, ctl_irq_en, ctl_halt, ctl_drain;
   logic          start_sw_clean, start_hw_clean, start_hw_up, teardown_done;
   logic [NB-1:0] disarm_mask;
   logic          run_req, running;
   logic [2:0]    state_o, prev_state_o;
   logic [3:0]    last_event_o;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk; // 4 ns period, 250 MHz

   sdma_lifecycle_ctrl #(.EVT_W(4), .NUM_BUFS(NB), .DISARM_LO(LO), .DISARM_HI(HI)) uut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
      .ctl_enable(ctl_enable), .ctl_irq_en(ctl_irq_en), .ctl_halt(ctl_halt), .ctl_drain(ctl_drain),
      .start_sw_clean(start_sw_clean), .start_hw_clean(start_hw_clean),
      .start_hw_up(start_hw_up), .teardown_done(teardown_done), .disarm_mask(disarm_mask),
      .run_req(run_req), .running(running), .state_o(state_o),
      .prev_state_o(prev_state_o), .last_event_o(last_event_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // drive one event, return after the edge that consumes it
   task automatic send(input int code);
      @(negedge clk);
      evt_valid = 1'b1;
      evt_code  = 4'(code);
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic idle1();
      @(negedge clk);
   endtask

   function automatic int strobes();
      return {start_sw_clean, start_hw_clean, start_hw_up, teardown_done};
   endfunction

   task automatic chk_ctl(input string req, input int en, input int halt, input int drain);
      chk(req, "enable", ctl_enable, en);
      chk(req, "irq_en", ctl_irq_en, en);
      chk(req, "halt", ctl_halt, halt);
      chk(req, "drain", ctl_drain, drain);
   endtask

   task automatic t_reset();
      chk("R1", "state", state_o, 0);
      chk("R1", "prev", prev_state_o, 0);
      chk("R1", "last", last_event_o, 0);
      chk("R1", "flag", run_req, 0);
      chk("R1", "strobes", strobes(), 0);
      chk("R1", "mask", int'(disarm_mask), 0);
      chk_ctl("R1", 0, 1, 0);
   endtask

   task automatic t_bringup_idle();
      send(1);  chk("R3", "go-start state", state_o, 1);
      send(2);  chk("R4", "started no flag", state_o, 2);
      chk_ctl("R11", 0, 1, 0);
      send(3);  chk("R6", "idle go-run state", state_o, 6);
      chk("R6", "flag", run_req, 1);
      chk_ctl("R11", 1, 0, 0);
      chk("R13", "prev", prev_state_o, 2);
      chk("R13", "last", last_event_o, 3);
   endtask

   task automatic t_ignored();
      send(10); chk("R2", "tick state", state_o, 6);
      chk("R2", "tick flag", run_req, 1);
      chk("R2", "tick last", last_event_o, 10);
      send(13); chk("R2", "bad code state", state_o, 6);
      chk("R2", "bad code last", last_event_o, 10);
      chk("R2", "bad code strobes", strobes(), 0);
   endtask

   task automatic t_idle_recover();
      logic [NB-1:0] exp_mask = '0;
      for (int i = LO; i < HI; i++) exp_mask[i] = 1'b1;
      send(7);  chk("R6", "go-idle state", state_o, 5);
      chk("R6", "go-idle flag", run_req, 0);
      send(6);  chk("R8", "halted state", state_o, 4);
      chk("R8", "hw clean strobe", start_hw_clean, 1);
      chk_ctl("R11", 0, 1, 1);
      idle1();  chk("R12", "hw clean dropped", start_hw_clean, 0);
      send(3);  chk("R5", "flag set in hwclean", run_req, 1);
      chk("R5", "state kept", state_o, 4);
      send(5);  chk("R8", "cleaned state", state_o, 3);
      chk("R8", "sw clean strobe", start_sw_clean, 1);
      send(4);  chk("R9", "sw cleaned state", state_o, 1);
      chk("R9", "hw up strobe", start_hw_up, 1);
      chk("R9", "mask", int'(disarm_mask), int'(exp_mask));
      idle1();  chk("R9", "mask cleared", int'(disarm_mask), 0);
      chk("R12", "hw up dropped", start_hw_up, 0);
      send(2);  chk("R4", "remembered run", state_o, 6);
   endtask

   task automatic t_err_a();
      send(8);  chk("R7", "err A state", state_o, 3);
      chk("R7", "err A strobe", strobes(), 8);
      send(7);  chk("R5", "flag clear in swclean", run_req, 0);
      chk("R5", "state kept", state_o, 3);
      send(4);  chk("R9", "restart", state_o, 1);
      send(2);  chk("R4", "to idle", state_o, 2);
   endtask

   task automatic t_err_b();
      send(3);  chk("R6", "run again", state_o, 6);
      send(9);  chk("R7", "err B state", state_o, 5);
      chk("R7", "err B strobes", strobes(), 0);
      send(0);  chk("R10", "down from halt wait", state_o, 0);
      chk("R10", "sw clean on down", start_sw_clean, 1);
      chk("R10", "flag kept", run_req, 1);
   endtask

   task automatic t_down_paths();
      send(4);  chk("R3", "teardown in down", teardown_done, 1);
      chk("R3", "state kept", state_o, 0);
      send(4);  chk("R12", "teardown again", teardown_done, 1);
      idle1();  chk("R12", "teardown dropped", teardown_done, 0);
      send(0);  chk("R10", "go-down in down", strobes(), 0);
      send(3);  chk("R3", "go-run state", state_o, 1);
      chk("R3", "go-run flag", run_req, 1);
      send(0);  chk("R10", "down from startup", state_o, 0);
      chk("R10", "teardown from startup", teardown_done, 1);
      send(1);  send(2);
      chk("R4", "flag survives down", state_o, 6);
      send(6);  chk("R7", "hw halted from run", state_o, 3);
      chk("R7", "sw strobe", start_sw_clean, 1);
      send(0);  chk("R10", "down from swclean", state_o, 0);
      chk("R10", "no strobe from swclean", strobes(), 0);
      send(1);  send(7); send(2);
      chk("R4", "idle after go-idle", state_o, 2);
      send(0);  chk("R10", "teardown from idle", teardown_done, 1);
      chk("R13", "prev idle", prev_state_o, 2);
   endtask

   initial begin
      #80000;
      if (!done) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      idle1();
      t_reset();
      t_bringup_idle();
      t_ignored();
      t_idle_recover();
      t_err_a();
      t_err_b();
      t_down_paths();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule